// File: doc/BRIEF.md
# Bidirectional Port with Per-Bit Pullup Gating

An eight-pin general-purpose I/O slice sitting on a byte-wide register bus. Three registers control the pins: an output latch, a direction mask and a pullup-request mask. For every pin the block drives an output level, an output enable and a pullup enable toward the pad ring. It accepts the pad's sampled input level, which it passes through a two-flop synchronizer.

Reading the latch address does not return one register as a whole. Each bit of the result comes from the latch when that pin is an output and from the synchronized pad level when it is an input. A pullup request only reaches the pad while its pin is an input. Turning a pin into an output withdraws the pullup in the same cycle, with no further register write needed.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, and after it is released with no writes, the latch, direction and pullup registers are all zero. So pin_oe_o, pin_out_o and pin_pu_o are 0x00, and reads of 0x07 and 0x0F return 0x00.
- R2: A write to address 0x07 sets the direction mask. A 1 in bit k makes pin k an output. pin_oe_o equals the mask, and a read of 0x07 returns it unchanged.
- R3: A read of address 0x03 returns, in bit k, the latch bit when direction bit k is 1, and the synchronized pad bit when direction bit k is 0.
- R4: A write to 0x03 updates the latch whatever the direction mask holds. pin_out_o always equals the latch, so a value written while pins are inputs appears on read-back once those pins become outputs.
- R5: pin_pu_o bit k is 1 exactly when pullup bit k is 1 and direction bit k is 0. Setting a direction bit clears the matching pullup output on the same clock edge.
- R6: A write to address 0x0F sets the pullup-request mask, and a read of 0x0F returns it unchanged.
- R7: A change on pin_i first shows in an input-bit read of 0x03 after two rising clock edges. After only one edge, the read still shows the previous level.
- R8: Reads of any address other than 0x03, 0x07 and 0x0F return 0x00. Writes to such addresses leave all three registers unchanged.
- R9: rdata_o follows addr_i without a clock edge. A register write is sampled on the rising edge where wr_en_i is high and is visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| pin_i | input | 8 | Sampled pad input levels |
| pin_out_o | output | 8 | Output levels toward the pads |
| pin_oe_o | output | 8 | Output enables (1 = drive) |
| pin_pu_o | output | 8 | Pullup enables toward the pads |

## Verification
Each control register drives a pad output directly. A corrupted direction, latch or pullup bit therefore shows on pin_oe_o, pin_out_o or pin_pu_o in the cycle after the faulty write. It does not wait for a software read. A wrong per-bit read selection, or a wrong synchronizer depth, shows only at rdata_o on the data address. The bench reads that address at both one and two edges after a pad change to pin the latency exactly. Random direction and pullup mixes expose any bit that gates the pullup or selects the read source incorrectly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned BUS_AW  = 8;
  localparam logic [BUS_AW-1:0] ADDR_DATA = 8'h03;
  localparam logic [BUS_AW-1:0] ADDR_DIR  = 8'h07;
  localparam logic [BUS_AW-1:0] ADDR_PU   = 8'h0F;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PU   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] data_q_o,
  output logic [WIDTH-1:0] dir_q_o,
  output logic [WIDTH-1:0] pu_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '0;
      pu_q_o   <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_DATA: data_q_o <= wdata_i;  // written regardless of direction
        SEL_DIR:  dir_q_o  <= wdata_i;
        SEL_PU:   pu_q_o   <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_q_i,
  input  logic [WIDTH-1:0] dir_q_i,
  input  logic [WIDTH-1:0] pu_q_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] pu_o,
  output logic [WIDTH-1:0] data_rd_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign out_o[k]     = data_q_i[k];
    assign oe_o[k]      = dir_q_i[k];
    assign pu_o[k]      = pu_q_i[k] & ~dir_q_i[k];
    assign data_rd_o[k] = dir_q_i[k] ? data_q_i[k] : pin_sync_i[k];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = PORT_W,
  parameter int unsigned AW          = BUS_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic [WIDTH-1:0] pin_pu_o
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] data_q, dir_q, pu_q, pin_sync, data_rd;

  always_comb begin
    if (addr_i == AW'(ADDR_DATA))     sel = SEL_DATA;
    else if (addr_i == AW'(ADDR_DIR)) sel = SEL_DIR;
    else if (addr_i == AW'(ADDR_PU))  sel = SEL_PU;
    else                              sel = SEL_NONE;
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .data_q_o (data_q),
    .dir_q_o  (dir_q),
    .pu_q_o   (pu_q)
  );

  gpio_pin_ctrl #(.WIDTH(WIDTH)) u_pins (
    .data_q_i   (data_q),
    .dir_q_i    (dir_q),
    .pu_q_i     (pu_q),
    .pin_sync_i (pin_sync),
    .out_o      (pin_out_o),
    .oe_o       (pin_oe_o),
    .pu_o       (pin_pu_o),
    .data_rd_o  (data_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = data_rd;
      SEL_DIR:  rdata_o = dir_q;
      SEL_PU:   rdata_o = pu_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned AW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [WIDTH-1:0] pin_out_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] pin_pu_o
);
  logic mapped;
  assign mapped = (addr_i == AW'(ADDR_DATA)) || (addr_i == AW'(ADDR_DIR)) ||
                  (addr_i == AW'(ADDR_PU));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert ((pin_oe_o | pin_out_o | pin_pu_o) == '0);
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(ADDR_DIR)) |=> pin_oe_o == $past(wdata_i));

  // R4
  data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(ADDR_DATA)) |=> pin_out_o == $past(wdata_i));

  // R5
  pu_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_pu_o & pin_oe_o) == '0);

  // R6
  pu_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(ADDR_PU)) |=> pin_pu_o == ($past(wdata_i) & ~pin_oe_o));

  // R3
  out_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADDR_DATA)) |-> (rdata_o & pin_oe_o) == (pin_out_o & pin_oe_o));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == '0);

  // R8
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mapped) |=> ($stable(pin_oe_o) && $stable(pin_out_o) && $stable(pin_pu_o)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .pin_pu_o  (pin_pu_o)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pin = '0;
  logic [7:0] pin_out, pin_oe, pin_pu;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_data = '0, m_dir = '0, m_pu = '0, m_pin = '0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_port dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_en_i (wr_en),
    .wdata_i (wdata), .rdata_o (rdata), .pin_i (pin),
    .pin_out_o (pin_out), .pin_oe_o (pin_oe), .pin_pu_o (pin_pu)
  );

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h03:   return (m_dir & m_data) | (~m_dir & m_pin);
      8'h07:   return m_dir;
      8'h0F:   return m_pu;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_pu();
    return m_pu & ~m_dir;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      8'h03: m_data = d;
      8'h07: m_dir = d;
      8'h0F: m_pu = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    addr = a;
    #1;
    chk(req, rdata, exp_read(a));
  endtask

  task automatic set_pin(input logic [7:0] v);
    @(negedge clk);
    pin = v;
    @(negedge clk);
    @(negedge clk);
    m_pin = v;
  endtask

  task automatic chk_outs(input string req);
    chk({req, " oe"}, pin_oe, m_dir);
    chk({req, " out"}, pin_out, m_data);
    chk({req, " pu"}, pin_pu, exp_pu());
  endtask

  function automatic logic [7:0] rand_unmapped();
    logic [7:0] a;
    do a = 8'($urandom); while (a == 8'h03 || a == 8'h07 || a == 8'h0F);
    return a;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_6a10));
    #1;
    // R1: during reset
    chk("R1 reset oe", pin_oe, 8'h00);
    chk("R1 reset pu", pin_pu, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1");
    rd_chk("R1 dir", 8'h07);
    rd_chk("R1 pu", 8'h0F);

    // R6 / R5: pullups on inputs
    wr(8'h0F, 8'hA5);
    rd_chk("R6 pu readback", 8'h0F);
    chk("R5 pu input", pin_pu, 8'hA5);
    // R2 / R5: direction removes pullup
    wr(8'h07, 8'h0F);
    rd_chk("R2 dir readback", 8'h07);
    chk_outs("R5 dir gating");

    // R4: write while inputs, then make outputs
    wr(8'h03, 8'h3C);
    chk("R4 latch on out", pin_out, 8'h3C);
    wr(8'h07, 8'hF0);
    rd_chk("R4 readback after dir", 8'h03);

    // R9: write visible at edge, read combinational
    @(negedge clk);
    addr = 8'h07; wdata = 8'h55; wr_en = 1'b1;
    #1 chk("R9 before edge", rdata, 8'hF0);
    @(posedge clk); #1;
    wr_en = 1'b0; m_dir = 8'h55;
    chk("R9 after edge", rdata, 8'h55);
    addr = 8'h0F; #1;
    chk("R9 comb addr", rdata, m_pu);

    // R7: synchronizer latency on input bits
    wr(8'h07, 8'h00);
    set_pin(8'h00);
    @(negedge clk);
    pin = 8'hC3;
    @(negedge clk);
    rd_chk("R7 one edge", 8'h03);
    @(negedge clk);
    m_pin = 8'hC3;
    rd_chk("R7 two edges", 8'h03);

    // R8: unmapped
    for (int i = 0; i < 6; i++) begin
      logic [7:0] a;
      a = rand_unmapped();
      wr(a, 8'($urandom));
      rd_chk("R8 unmapped read", a);
      chk_outs("R8 unmapped write");
      rd_chk("R8 dir kept", 8'h07);
      rd_chk("R8 pu kept", 8'h0F);
    end

    // R3: random mixes
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: wr(8'h03, 8'($urandom));
        1: wr(8'h07, 8'($urandom));
        2: wr(8'h0F, 8'($urandom));
        3: set_pin(8'($urandom));
        default: wr(rand_unmapped(), 8'($urandom));
      endcase
      rd_chk("R3 data mix", 8'h03);
      chk_outs("R5 mix");
      if (op == 1) rd_chk("R2 mix", 8'h07);
      if (op == 2) rd_chk("R6 mix", 8'h0F);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule